// File: doc/BRIEF.md
# Host Memory Access Port

This block gives a host processor random access to a word-organised memory that otherwise serves a pixel-processing pipeline. It owns the memory array, a bidirectional data bus (modelled as separate input, output and enable signals), a host address bus and two active-low strobes, one for reading and one for writing. The meaning of the strobes depends on the three-bit function code. In the two host codes the strobes form a RAM port that runs independently of the processing clock. In every other code the bus carries the pipeline's processed output and the read strobe only opens the bus driver.

The host strobes are brought into the internal clock domain by two-stage synchronisers. A falling strobe captures the host address. A rising write strobe stores the word on the bus at that address. A narrow host code moves only the lower part of each word, so a host with a 16-bit bus can still use the port. An active-low flash clear empties the whole array and the processed-output register in one clock.

Top module: `hostmem_port`

## Requirements
- R1: `dio_oe` is high exactly while `rd_n` is low, in every function code, with no clock delay. When `dio_oe` is low the bus is high-impedance.
- R2: In a host code, the read address is taken from `host_addr_i` on the third rising clock edge after `rd_n` falls. From that edge on, `dio_o` shows the word at that address, and later changes of `host_addr_i` during the same strobe have no effect.
- R3: In a host code, the write address is captured from `host_addr_i` on the third rising edge after `wr_n` falls. `dio_i` is stored at that address on the third rising edge after `wr_n` rises.
- R4: Function code 3'b111 (narrow host mode): a write changes only bits 15:0 of the addressed word. Bits 23:16 keep their previous value.
- R5: In the narrow host mode, read data on `dio_o` has bits 23:16 forced to zero and bits 15:0 taken from the addressed word.
- R6: Function codes 3'b000 to 3'b101 (processing codes): `dio_o` equals `proc_data_i` as sampled on the previous rising edge. `wr_n` and `host_addr_i` leave the memory unchanged.
- R7: On every rising edge with `flash_clr_n` low, all memory words and the processed-output register become zero.
- R8: Function code 3'b110 selects the full-width host mode, in which all 24 bits are written and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset of the synchronisers and registers |
| mode_i | input | 3 | Function code |
| flash_clr_n | input | 1 | Active-low clear of the whole array and the output register |
| host_addr_i | input | 10 | Host word address |
| rd_n | input | 1 | Host read strobe / output enable, active low |
| wr_n | input | 1 | Host write strobe, active low |
| proc_data_i | input | 24 | Processed data from the pipeline |
| dio_i | input | 24 | Bus data driven by the host |
| dio_o | output | 24 | Bus data driven by the block |
| dio_oe | output | 1 | Bus driver enable |

## Verification
The bus enable follows the read strobe in the same cycle, so the bench compares it 5 ns after every rising edge. The processed output is due one edge after the data is sampled. The reference model records the input at each edge and compares it 5 ns later. A host read is valid from the third edge after the strobe falls, and a host write takes effect on the third edge after the strobe rises. The bench therefore holds the address and data four cycles after each strobe edge and samples read data only after that. Checks that memory was left untouched bring the word back out through a later host read.

// File: rtl/hostmem_port.sv
module hostmem_port #(
  parameter int AW = 10,
  parameter int DW = 24,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          flash_clr_n,
  input  logic [AW-1:0] host_addr_i,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] proc_data_i,
  input  logic [DW-1:0] dio_i,
  output logic [DW-1:0] dio_o,
  output logic          dio_oe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic rd_s1, rd_s2, rd_q, wr_s1, wr_s2, wr_q;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] out_q, rdata;

  wire host_md   = (mode_i[2:1] == 2'b11);
  wire narrow    = (mode_i == 3'b111);
  wire rd_fall   = rd_q & ~rd_s2;
  wire wr_fall   = wr_q & ~wr_s2;
  wire wr_commit = ~wr_q & wr_s2 & host_md & flash_clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rd_s1, rd_s2, rd_q} <= 3'b111;
      {wr_s1, wr_s2, wr_q} <= 3'b111;
      rd_addr <= '0;
      wr_addr <= '0;
      out_q   <= '0;
    end else begin
      {rd_s1, rd_s2, rd_q} <= {rd_n, rd_s1, rd_s2};
      {wr_s1, wr_s2, wr_q} <= {wr_n, wr_s1, wr_s2};
      if (rd_fall && host_md) rd_addr <= host_addr_i;
      if (wr_fall && host_md) wr_addr <= host_addr_i;
      out_q <= flash_clr_n ? proc_data_i : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!flash_clr_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_commit) begin
      mem[wr_addr] <= narrow ? {mem[wr_addr][DW-1:NW], dio_i[NW-1:0]} : dio_i;
    end
  end

  assign rdata  = mem[rd_addr];
  assign dio_o  = !host_md ? out_q
                : narrow   ? {{(DW-NW){1'b0}}, rdata[NW-1:0]}
                :            rdata;
  assign dio_oe = ~rd_n;
endmodule

// File: rtl/hostmem_port_chk.sv
module hostmem_port_chk #(
  parameter int DW = 24,
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_i,
  input logic          flash_clr_n,
  input logic          wr_n,
  input logic [DW-1:0] proc_data_i,
  input logic [DW-1:0] dio_o,
  input logic          wr_commit
);
  wire host_md = (mode_i[2:1] == 2'b11);

  p_sync_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_md && $past(rst_n) && $past(flash_clr_n)) |-> dio_o == $past(proc_data_i));

  p_no_host_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_md |-> !wr_commit);

  p_clear_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_clr_n && !host_md) |=> (host_md || dio_o == '0));

  p_narrow_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b111) |-> dio_o[DW-1:NW] == '0);

  p_commit_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> ($past(wr_n, 2) && !$past(wr_n, 3)));
endmodule

bind hostmem_port hostmem_port_chk #(.DW(DW), .NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .flash_clr_n(flash_clr_n),
  .wr_n(wr_n), .proc_data_i(proc_data_i), .dio_o(dio_o), .wr_commit(wr_commit)
);

// File: tb/hostmem_port_tb_top.sv
`timescale 1ns/1ps
module hostmem_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = 3'b110;
  logic        flash_clr_n = 1'b1;
  logic [9:0]  host_addr_i = '0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [23:0] proc_data_i = '0;
  logic [23:0] dio_i = '0;
  logic [23:0] dio_o;
  logic        dio_oe;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [23:0] ref_mem [1024];
  logic [23:0] exp_out = '0;

  always #10 clk = ~clk;

  hostmem_port dut_i (.*);

  task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock reference model: bus enable and processed output path
  initial forever begin
    @(posedge clk);
    exp_out = (!rst_n || !flash_clr_n) ? 24'h0 : proc_data_i;
    #5;
    if (rst_n) begin
      chk({23'h0, dio_oe}, {23'h0, ~rd_n}, "R1 enable");
      if (mode_i[2:1] != 2'b11) chk(dio_o, exp_out, "R6 processed out");
    end
  end

  initial forever begin
    @(negedge clk);
    proc_data_i = proc_data_i * 24'd13 + 24'h0B1F07;
  end

  task automatic host_write(input logic [9:0] a, input logic [23:0] d);
    @(negedge clk); host_addr_i = a; dio_i = d; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    if (mode_i == 3'b110) ref_mem[a] = d;
    else if (mode_i == 3'b111) ref_mem[a] = {ref_mem[a][23:16], d[15:0]};
  endtask

  task automatic host_read(input logic [9:0] a, input logic [23:0] exp, input string tag);
    @(negedge clk); host_addr_i = a; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(dio_o, exp, tag);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode_i = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({23'h0, dio_oe}, 24'h0, "R1 reset enable low");
    rst_n = 1'b1;
    // R7: flash clear empties the array
    @(negedge clk); flash_clr_n = 1'b0;
    @(negedge clk); flash_clr_n = 1'b1;
    for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
    host_read(10'd5, 24'h0, "R7 cleared word");
    // R3/R8: full-width writes, corners of the address range
    host_write(10'd0, 24'hABCDEF);
    host_write(10'd1023, 24'h123456);
    host_write(10'd10, 24'hFEDCBA);
    host_read(10'd0, ref_mem[0], "R8 read addr 0");
    host_read(10'd1023, ref_mem[1023], "R3 read addr 1023");
    host_read(10'd10, 24'hFEDCBA, "R3 read addr 10");
    // R2: address changes after capture are ignored
    @(negedge clk); host_addr_i = 10'd0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    host_addr_i = 10'd1023;
    repeat (4) @(negedge clk);
    chk(dio_o, 24'hABCDEF, "R2 address held");
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    // R4/R5: narrow mode
    set_mode(3'b111);
    host_write(10'd10, 24'h771357);
    host_read(10'd10, 24'h001357, "R5 narrow read");
    host_read(10'd1023, 24'h003456, "R5 narrow read upper zero");
    set_mode(3'b110);
    host_read(10'd10, 24'hFE1357, "R4 upper bits kept");
    // R6: processing codes ignore write strobe and address
    for (int m = 0; m < 6; m++) begin
      set_mode(m[2:0]);
      host_write(10'd10, 24'h0F0F0F);
      @(negedge clk); rd_n = 1'b0;
      repeat (3) @(negedge clk); rd_n = 1'b1;
    end
    set_mode(3'b110);
    host_read(10'd10, 24'hFE1357, "R6 memory untouched");
    // R7: flash clear in a processing code zeroes output and array
    set_mode(3'b000);
    @(negedge clk); flash_clr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(dio_o, 24'h0, "R7 output cleared");
    flash_clr_n = 1'b1;
    set_mode(3'b110);
    host_read(10'd10, 24'h0, "R7 word cleared");
    host_read(10'd1023, 24'h0, "R7 top word cleared");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule